// File: doc/BRIEF.md
# Packet Buffer Host Access Controller

This block sits between a host register port and the network side of a packet controller, sharing two on-board byte buffers, one for receive and one for transmit. The host loads a byte pointer and then moves data through the data ports. Each data access reads or writes whichever buffer is currently switched onto the host side, and then advances the pointer. The pointer's high bits are ignored when a buffer is addressed, so any pointer value lands inside the buffer.

A mode register controls three things: which buffer faces the host, starting a transmission, and arming reception. A transmit sends the bytes from the pointer's buffer index up to the last buffer byte. The host therefore places a frame of length L at index DEPTH-L. Reception stores incoming bytes from index 0 and latches the frame length when the final byte arrives. Both the transmit-start bit and the receive-arm bit drop by themselves when their operation finishes.

A status register shows the armed and busy flags and active-low completion indications. A write to a dedicated reset offset returns the block to its reset state. The network side is a plain byte stream: valid/ready for transmit, and valid/last for receive.

Top module: `pbuf_host_ctrl`

## Requirements
- R1: A 16-bit write to offset 0x10 loads the byte pointer. Each host read or write of offset 0x14 or 0x15 accesses the byte at the pointer and then advances the pointer by one.
- R2: Only the low log2(DEPTH) pointer bits address a buffer (DEPTH is a power of two), so a pointer value of DEPTH+n reaches byte n.
- R3: Bit 0 of the mode register (offset 0x12) selects which buffer the data ports reach: 1 selects the receive buffer, 0 selects the transmit buffer. Host reads and writes touch only the selected buffer.
- R4: Writing mode bit 5 as 1 while no transmit is running starts a transmit. The transmit streams bytes from the pointer's buffer index through index DEPTH-1 on the valid/ready port, with last set only on byte DEPTH-1. Status bit 4 and mode readback bit 5 read 1 until that final byte is accepted, then read 0.
- R5: Writing mode bit 6 as 1 arms reception and restarts storage at receive-buffer byte 0. Each byte offered while armed goes to the next index, wrapping at DEPTH. The byte flagged last disarms reception, after which status bit 5 and mode bit 6 read 0.
- R6: A read of offset 0x10 returns the total byte count of the last completed frame, including bytes that wrapped. The count is latched at completion and does not change until the next frame completes.
- R7: Status (offset 0x13) reads as follows: bits 7..6 = 0, bit 5 = armed, bit 4 = transmitting, bit 3 = 0, bit 2 = 1, bit 1 = receive-done-n, bit 0 = transmit-done-n. Bit 1 goes to 0 when a frame completes and back to 1 on re-arming. Bit 0 goes to 0 when a transmit completes and back to 1 when the next transmit starts.
- R8: Bytes offered on the receive port while reception is not armed are dropped. Buffer contents, byte count and status all stay unchanged.
- R9: A write to offset 0x17 with any data value, or the rst input, returns the pointer, mode, status and count to their reset values: pointer 0, mode 0x00, status 0x07, count 0. Buffer contents are kept.
- R10: host_rdata shows the result of a read in the cycle after the read strobe is sampled. A mode read returns {0, armed, transmitting, 0000, select bit}, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Host register offset |
| host_wdata | input | 16 | Host write data (pointer uses all bits, bytes use 7:0) |
| host_rdata | output | 16 | Host read data, valid the cycle after the strobe |
| net_tx_valid | output | 1 | Transmit byte available |
| net_tx_data | output | 8 | Transmit byte |
| net_tx_last | output | 1 | Final byte of the transmit |
| net_tx_ready | input | 1 | Network side accepts the transmit byte |
| net_rx_valid | input | 1 | Receive byte offered |
| net_rx_data | input | 8 | Receive byte |
| net_rx_last | input | 1 | Final byte of the received frame |

## Verification
The bench builds the block with DEPTH = 32. At that size every pointer index can be visited and checked, including each alias one buffer length higher. The same size allows a transmit to be started from every one of the 32 start indices and from one wrapped pointer value. It also allows receive frames of every length from 1 to 40, so frames that overrun the buffer wrap and their latched counts exceed the buffer size, and the whole receive buffer can be compared against a model after each frame.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam logic [4:0] OFF_PTR  = 5'h10;
  localparam logic [4:0] OFF_MODE = 5'h12;
  localparam logic [4:0] OFF_STAT = 5'h13;
  localparam logic [4:0] OFF_RXD  = 5'h14;
  localparam logic [4:0] OFF_TXD  = 5'h15;
  localparam logic [4:0] OFF_RST  = 5'h17;

  localparam int MB_SEL = 0;
  localparam int MB_TX  = 5;
  localparam int MB_RX  = 6;

  typedef enum logic [1:0] {SRC_REG, SRC_RXB, SRC_TXB} rd_src_e;
  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_SEND} tx_state_e;
endpackage

// File: rtl/pbuf_ram.sv
module pbuf_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/pbuf_rx_engine.sv
module pbuf_rx_engine #(
  parameter int DEPTH = 2048,
  parameter int CNT_W = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             restart,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [7:0]       wdata,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  logic [AW-1:0]    idx_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] count_q;

  assign we    = armed && in_valid;
  assign done  = we && in_last;
  assign waddr = idx_q;
  assign wdata = in_data;
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      run_q   <= '0;
      count_q <= '0;
    end else if (restart) begin
      idx_q <= '0;
      run_q <= '0;
    end else if (we) begin
      if (in_last) begin
        idx_q   <= '0;
        run_q   <= '0;
        count_q <= run_q + CNT_W'(1);
      end else begin
        idx_q <= idx_q + AW'(1);
        run_q <= run_q + CNT_W'(1);
      end
    end
  end

  // R6: the latched length only moves on frame completion
  p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(count_q));
endmodule

// File: rtl/pbuf_tx_engine.sv
module pbuf_tx_engine #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] start_idx,
  input  logic [7:0]    rd_q,
  input  logic          out_ready,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          done
);
  import pbuf_pkg::*;

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  tx_state_e     st_q;
  logic [AW-1:0] addr_q;

  assign rd_addr   = addr_q;
  assign busy      = (st_q != TX_IDLE);
  assign out_valid = (st_q == TX_SEND);
  assign out_data  = rd_q;
  assign out_last  = out_valid && (addr_q == LAST_IDX);
  assign done      = out_last && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TX_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (go) begin
          addr_q <= start_idx;
          st_q   <= TX_FETCH;
        end
        TX_FETCH: st_q <= TX_SEND;
        TX_SEND: if (out_ready) begin
          if (addr_q == LAST_IDX) begin
            st_q <= TX_IDLE;
          end else begin
            addr_q <= addr_q + AW'(1);
            st_q   <= TX_FETCH;
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  // R4: an offered byte is held, with its last flag, until taken
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_last) && $stable(addr_q)));

  // R4: acceptance of the final byte ends the transmit
  p_tx_end_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/pbuf_host_ctrl.sv
module pbuf_host_ctrl #(
  parameter int DEPTH = 2048,
  parameter int PTR_W = 16,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [4:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        net_tx_valid,
  output logic [7:0]  net_tx_data,
  output logic        net_tx_last,
  input  logic        net_tx_ready,
  input  logic        net_rx_valid,
  input  logic [7:0]  net_rx_data,
  input  logic        net_rx_last
);
  import pbuf_pkg::*;

  localparam int AW = $clog2(DEPTH);

  // host decode
  logic sys_rst, wr_ptr, wr_mode, is_data, data_wr, data_rd, data_acc;
  assign sys_rst  = rst || (host_wr && host_addr == OFF_RST);
  assign wr_ptr   = host_wr && (host_addr == OFF_PTR);
  assign wr_mode  = host_wr && (host_addr == OFF_MODE);
  assign is_data  = (host_addr == OFF_RXD) || (host_addr == OFF_TXD);
  assign data_wr  = host_wr && is_data;
  assign data_rd  = host_rd && !host_wr && is_data;
  assign data_acc = data_wr || data_rd;

  logic [PTR_W-1:0] ptr_q;
  logic [AW-1:0]    idx;
  logic             sel_rx_q, arm_q, rx_done_n_q, tx_done_n_q;
  assign idx = ptr_q[AW-1:0];

  // engine wires
  logic             tx_busy, tx_done, tx_go;
  logic [AW-1:0]    tx_eng_addr;
  logic [7:0]       tx_q;
  logic             rx_we, rx_done, rx_restart;
  logic [AW-1:0]    rx_waddr;
  logic [7:0]       rx_wdata, rx_q;
  logic [CNT_W-1:0] rx_count;

  assign tx_go      = wr_mode && host_wdata[MB_TX] && !tx_busy;
  assign rx_restart = wr_mode && host_wdata[MB_RX];

  // pointer
  always_ff @(posedge clk) begin
    if (sys_rst)       ptr_q <= '0;
    else if (wr_ptr)   ptr_q <= host_wdata[PTR_W-1:0];
    else if (data_acc) ptr_q <= ptr_q + PTR_W'(1);
  end

  // mode and completion flags
  always_ff @(posedge clk) begin
    if (sys_rst) begin
      sel_rx_q    <= 1'b0;
      arm_q       <= 1'b0;
      rx_done_n_q <= 1'b1;
      tx_done_n_q <= 1'b1;
    end else begin
      if (wr_mode) begin
        sel_rx_q <= host_wdata[MB_SEL];
        arm_q    <= host_wdata[MB_RX];
      end else if (rx_done) begin
        arm_q <= 1'b0;
      end
      if (rx_restart)   rx_done_n_q <= 1'b1;
      else if (rx_done) rx_done_n_q <= 1'b0;
      if (tx_go)        tx_done_n_q <= 1'b1;
      else if (tx_done) tx_done_n_q <= 1'b0;
    end
  end

  // buffers
  pbuf_ram #(.DEPTH(DEPTH), .DW(8), .AW(AW)) u_txbuf (
    .clk   (clk),
    .we    (data_wr && !sel_rx_q),
    .waddr (idx),
    .wdata (host_wdata[7:0]),
    .re    (tx_busy || (data_rd && !sel_rx_q)),
    .raddr (tx_busy ? tx_eng_addr : idx),
    .q     (tx_q)
  );

  pbuf_ram #(.DEPTH(DEPTH), .DW(8), .AW(AW)) u_rxbuf (
    .clk   (clk),
    .we    (rx_we || (data_wr && sel_rx_q)),
    .waddr (rx_we ? rx_waddr : idx),
    .wdata (rx_we ? rx_wdata : host_wdata[7:0]),
    .re    (data_rd && sel_rx_q),
    .raddr (idx),
    .q     (rx_q)
  );

  pbuf_tx_engine #(.DEPTH(DEPTH), .AW(AW)) u_tx (
    .clk       (clk),
    .rst       (sys_rst),
    .go        (tx_go),
    .start_idx (idx),
    .rd_q      (tx_q),
    .out_ready (net_tx_ready),
    .rd_addr   (tx_eng_addr),
    .busy      (tx_busy),
    .out_valid (net_tx_valid),
    .out_data  (net_tx_data),
    .out_last  (net_tx_last),
    .done      (tx_done)
  );

  pbuf_rx_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_rx (
    .clk      (clk),
    .rst      (sys_rst),
    .armed    (arm_q),
    .restart  (rx_restart),
    .in_valid (net_rx_valid),
    .in_data  (net_rx_data),
    .in_last  (net_rx_last),
    .we       (rx_we),
    .waddr    (rx_waddr),
    .wdata    (rx_wdata),
    .done     (rx_done),
    .count    (rx_count)
  );

  // host read path
  logic [7:0]  status_b, mode_b;
  rd_src_e     src_q;
  logic [15:0] reg_q;
  assign status_b = {2'b00, arm_q, tx_busy, 1'b0, 1'b1, rx_done_n_q, tx_done_n_q};
  assign mode_b   = {1'b0, arm_q, tx_busy, 4'b0000, sel_rx_q};

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      src_q <= SRC_REG;
      reg_q <= '0;
    end else if (host_rd && !host_wr) begin
      if (is_data) begin
        src_q <= sel_rx_q ? SRC_RXB : SRC_TXB;
      end else begin
        src_q <= SRC_REG;
        unique case (host_addr)
          OFF_PTR:  reg_q <= 16'(rx_count);
          OFF_MODE: reg_q <= {8'h00, mode_b};
          OFF_STAT: reg_q <= {8'h00, status_b};
          default:  reg_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_RXB: host_rdata = {8'h00, rx_q};
      SRC_TXB: host_rdata = {8'h00, tx_q};
      default: host_rdata = reg_q;
    endcase
  end

  // R1: a data access steps the pointer by exactly one
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !sys_rst) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

  // R8: nothing is written from the network while disarmed
  p_unarmed_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !arm_q |-> !rx_we);

  // R5: frame completion disarms reception
  p_rx_disarm_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !wr_mode && !sys_rst) |=> !arm_q);

  // R7: transmit completion pulls its indication low
  p_tx_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !sys_rst) |=> !tx_done_n_q);
endmodule

// File: tb/pbuf_host_ctrl_bench.sv
module pbuf_host_ctrl_bench;
  import pbuf_pkg::*;

  localparam int D = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        net_tx_valid, net_tx_last;
  logic [7:0]  net_tx_data;
  logic        net_tx_ready = 1'b0;
  logic        net_rx_valid = 1'b0, net_rx_last = 1'b0;
  logic [7:0]  net_rx_data = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] rxm [D];
  int  cnt_m = 0;
  bit  rxn_m = 1, txn_m = 1;

  always #4 clk = ~clk;

  pbuf_host_ctrl #(.DEPTH(D), .PTR_W(16), .CNT_W(16)) u_pbuf_host_ctrl (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .net_tx_valid(net_tx_valid), .net_tx_data(net_tx_data),
    .net_tx_last(net_tx_last), .net_tx_ready(net_tx_ready),
    .net_rx_valid(net_rx_valid), .net_rx_data(net_rx_data),
    .net_rx_last(net_rx_last)
  );

  function automatic logic [7:0] fpat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] gpat(input int i);
    return 8'((i * 5 + 200) & 255);
  endfunction
  function automatic logic [7:0] hpat(input int k, input int len);
    return 8'((k * 13 + len * 3 + 1) & 255);
  endfunction
  function automatic logic [15:0] stat(input bit a, input bit b, input bit rn, input bit tn);
    return {8'h00, 2'b00, a, b, 1'b0, 1'b1, rn, tn};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic end_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic rx_frame(input int len, input bit armed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      net_rx_valid = 1'b1;
      net_rx_data  = hpat(k, len);
      net_rx_last  = (k == len - 1);
      if (armed) rxm[k % D] = hpat(k, len);
    end
    @(negedge clk);
    net_rx_valid = 1'b0; net_rx_last = 1'b0;
  endtask

  task automatic rx_compare(input string tag);
    logic [15:0] d;
    hwr(OFF_MODE, 16'h0001);
    hwr(OFF_PTR, 16'h0000);
    for (int i = 0; i < D; i++) begin
      hrd(OFF_RXD, d);
      check(tag, d, {8'h00, rxm[i]});
    end
  endtask

  task automatic tx_run(input int s, input bit stall);
    logic [15:0] d;
    int base, got, cyc;
    bit done;
    base = s % D; got = 0; cyc = 0; done = 0;
    net_tx_ready = 1'b0;
    hwr(OFF_PTR, 16'(s));
    hwr(OFF_MODE, 16'h0020);
    txn_m = 1;
    if (stall) begin
      hrd(OFF_STAT, d);
      check("R4/R7 busy status", d, stat(0, 1, rxn_m, 1));
      hrd(OFF_MODE, d);
      check("R4 mode readback busy", d, 16'h0020);
    end
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      net_tx_ready = ((cyc % 3) != 1);
      if (net_tx_valid && net_tx_ready) begin
        check("R4 tx byte", {8'h00, net_tx_data}, {8'h00, fpat(base + got)});
        check("R4 tx last", {15'h0, net_tx_last}, {15'h0, (base + got == D - 1)});
        got++;
        if (net_tx_last) done = 1;
      end
    end
    @(negedge clk);
    net_tx_ready = 1'b0;
    txn_m = 0;
    check("R4 tx length", 16'(got), 16'(D - base));
    hrd(OFF_STAT, d);
    check("R7 tx done status", d, stat(0, 0, rxn_m, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      end_run();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    hrd(OFF_STAT, d); check("R9 reset status", d, 16'h0007);
    hrd(OFF_PTR, d);  check("R9 reset count", d, 16'h0000);
    hrd(OFF_MODE, d); check("R10 reset mode", d, 16'h0000);
    hrd(5'h03, d);    check("R10 unmapped", d, 16'h0000);

    // fill transmit buffer, sequential readback through both ports
    hwr(OFF_MODE, 16'h0000);
    hwr(OFF_PTR, 16'h0000);
    for (int i = 0; i < D; i++) hwr((i % 2) ? OFF_RXD : OFF_TXD, {8'h00, fpat(i)});
    hwr(OFF_PTR, 16'h0000);
    for (int i = 0; i < D; i++) begin
      hrd((i % 2) ? OFF_TXD : OFF_RXD, d);
      check("R1 sequential read", d, {8'h00, fpat(i)});
    end
    // wrapped pointer aliases
    for (int i = 0; i < D; i++) begin
      hwr(OFF_PTR, 16'(D * (1 + i % 5) + i + ((i % 4 == 3) ? 16'h8000 : 0)));
      hrd(OFF_TXD, d);
      check("R2 wrapped alias", d, {8'h00, fpat(i)});
    end

    // receive buffer through the select bit
    hwr(OFF_MODE, 16'h0001);
    hwr(OFF_PTR, 16'(D));
    for (int i = 0; i < D; i++) begin
      hwr(OFF_RXD, {8'h00, gpat(i)});
      rxm[i] = gpat(i);
    end
    rx_compare("R3 rx buffer");
    hwr(OFF_MODE, 16'h0000);
    hwr(OFF_PTR, 16'h0000);
    for (int i = 0; i < D; i++) begin
      hrd(OFF_RXD, d);
      check("R3 tx buffer untouched", d, {8'h00, fpat(i)});
    end

    // frames of every length 1..40
    for (int len = 1; len <= 40; len++) begin
      hwr(OFF_MODE, 16'h0041);
      rxn_m = 1;
      hrd(OFF_STAT, d); check("R5 armed status", d, stat(1, 0, 1, txn_m));
      hrd(OFF_MODE, d); check("R10 mode readback", d, 16'h0041);
      rx_frame(len, 1);
      rxn_m = 0; cnt_m = len;
      hrd(OFF_STAT, d); check("R5/R7 frame done status", d, stat(0, 0, 0, txn_m));
      hrd(OFF_PTR, d);  check("R6 byte count", d, 16'(cnt_m));
      rx_compare("R5 rx contents");
    end

    // unarmed traffic is dropped
    rx_frame(6, 0);
    hrd(OFF_STAT, d); check("R8 status after drop", d, stat(0, 0, 0, txn_m));
    hrd(OFF_PTR, d);  check("R8 count after drop", d, 16'(cnt_m));
    rx_compare("R8 contents after drop");

    // transmit from every start index, first one stalled
    for (int s = 0; s < D; s++) tx_run(s, s == 0);
    tx_run(D + 7, 1'b1);
    hrd(OFF_PTR, d); check("R6 count holds over tx", d, 16'(cnt_m));

    // soft reset
    hwr(OFF_RST, 16'h00A5);
    rxn_m = 1; txn_m = 1;
    hrd(OFF_STAT, d); check("R9 soft reset status", d, 16'h0007);
    hrd(OFF_PTR, d);  check("R9 soft reset count", d, 16'h0000);
    hrd(OFF_MODE, d); check("R9 soft reset mode", d, 16'h0000);
    hrd(OFF_TXD, d);  check("R9 pointer cleared", d, {8'h00, fpat(0)});
    hrd(OFF_TXD, d);  check("R9 pointer steps", d, {8'h00, fpat(1)});

    end_run();
  end
endmodule